// File: doc/BRIEF.md
# LCD Panel Video Timing Generator

This block produces the raster timing for a 640 by 480 LCD panel from one 48 MHz clock. A pixel counter walks each line through its active, front porch, sync and back porch intervals. A line counter walks the frame through the same four intervals. Active-low horizontal and vertical sync, a data-enable window and the current pixel position are decoded from the two counters.

A downstream line buffer is kept one line ahead of the panel. One line before every active line, the block pulses a fill request and presents the frame-buffer address of the row to fetch. A row address register steps by the line pitch on every request and goes back to the frame base during vertical blanking. The timing needs no configuration. It starts at the beginning of the last blanking line, so the first line 0 is prefetched like every later one.

Top module: `lcd_timing_gen`

## Requirements
- R1: While rst_ni is low, hsync_no and vsync_no are 1, de_o and fill_req_o are 0, and row_addr_o equals BASE_ADDR.
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (640+16+96+48 = 800 by default). x_o counts 0 up to that total minus 1, then wraps to 0.
- R3: hsync_no is 0 exactly for x_o from H_ACTIVE+H_FP through H_ACTIVE+H_FP+H_SYNC-1, and 1 elsewhere.
- R4: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (480+10+2+33 = 525 by default). y_o advances only when x_o wraps. vsync_no is 0 for whole lines V_ACTIVE+V_FP through V_ACTIVE+V_FP+V_SYNC-1.
- R5: de_o is 1 exactly when x_o < H_ACTIVE and y_o < V_ACTIVE. x_o and y_o then give the pixel being shown.
- R6: fill_req_o is a one-clock pulse at x_o = 0 of line V_TOTAL-1 and of lines 0 to V_ACTIVE-2, which is one line before each active line. It is 0 at every other time.
- R7: While fill_req_o is 1, row_addr_o equals BASE_ADDR + n*LINE_PITCH, where n is the active line about to be fetched (LINE_PITCH = 640 by default). Each request moves the register on by one pitch.
- R8: The row address returns to BASE_ADDR during vertical blanking, so the request made before line 0 of every frame carries BASE_ADDR.
- R9: On the first clock edge after reset is released, the position becomes x_o = 0, y_o = V_TOTAL-1, and a fill request for line 0 is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, 48 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable for the active pixel window |
| fill_req_o | output | 1 | One-clock request to fetch the next active row |
| row_addr_o | output | AW | Frame-buffer address of the row being requested |
| x_o | output | XW | Pixel position within the line |
| y_o | output | YW | Line position within the frame |

## Verification
Every output is decoded from the counter and address registers with no further pipeline stage. So each result is due in the same cycle as the counter state it reflects. The first edge after reset is released makes cycle 1: x_o = 0, y_o = V_TOTAL-1, and the first fill request. After that, each edge moves the position by exactly one pixel. The bench builds its expected stream from the cycle number alone. It samples on the falling edge, one item for each rising edge since release, and checks the address only in cycles where a request is due. The instance uses a scaled-down raster, so several complete frames and their wraps fit in the run.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  // true when v lies in [lo, lo+len)
  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned len);
    return (v >= lo) && (v < lo + len);
  endfunction

endpackage

// File: rtl/span_counter.sv
module span_counter #(
  parameter int unsigned TOTAL   = 800,
  parameter int unsigned W       = 10,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] LastVal = W'(TOTAL - 1);
  localparam logic [W-1:0] RstVal  = W'(RST_VAL);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RstVal;
    else if (step_i) cnt_q <= (cnt_q == LastVal) ? '0 : cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LastVal);

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LastVal);
  p_cnt_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o) |=> (cnt_o == '0));
  p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_o));
endmodule

// File: rtl/row_addr_reg.sv
module row_addr_reg #(
  parameter int unsigned AW         = 20,
  parameter int unsigned BASE_ADDR  = 0,
  parameter int unsigned LINE_PITCH = 640
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] Base  = AW'(BASE_ADDR);
  localparam logic [AW-1:0] Pitch = AW'(LINE_PITCH);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= Base;
    else if (reload_i) addr_q <= Base;
    else if (adv_i)    addr_q <= addr_q + Pitch;
  end

  assign addr_o = addr_q;

  p_addr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !reload_i) |=> (addr_o == $past(addr_o) + Pitch));
  p_addr_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (addr_o == Base));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int unsigned H_ACTIVE   = 640,
  parameter int unsigned H_FP       = 16,
  parameter int unsigned H_SYNC     = 96,
  parameter int unsigned H_BP       = 48,
  parameter int unsigned V_ACTIVE   = 480,
  parameter int unsigned V_FP       = 10,
  parameter int unsigned V_SYNC     = 2,
  parameter int unsigned V_BP       = 33,
  parameter int unsigned LINE_PITCH = 640,
  parameter int unsigned BASE_ADDR  = 0,
  parameter int unsigned AW         = 20,
  localparam int unsigned H_TOTAL   = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOTAL   = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int unsigned XW        = $clog2(H_TOTAL),
  localparam int unsigned YW        = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          de_o,
  output logic          fill_req_o,
  output logic [AW-1:0] row_addr_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  logic [XW-1:0] h_cnt;
  logic [YW-1:0] v_cnt;
  logic          h_last, v_last;
  logic          line_start, reload;

  // reset to the last pixel of the next-to-last line: the first edge opens
  // the final blanking line, whose start prefetches line 0
  span_counter #(.TOTAL(H_TOTAL), .W(XW), .RST_VAL(H_TOTAL - 1)) u_hcnt (
    .clk_i, .rst_ni, .step_i(1'b1), .cnt_o(h_cnt), .last_o(h_last)
  );

  span_counter #(.TOTAL(V_TOTAL), .W(YW), .RST_VAL(V_TOTAL - 2)) u_vcnt (
    .clk_i, .rst_ni, .step_i(h_last), .cnt_o(v_cnt), .last_o(v_last)
  );

  assign line_start = (h_cnt == '0);
  assign fill_req_o = line_start && (v_last || (int'(v_cnt) < int'(V_ACTIVE) - 1));
  assign reload     = line_start && (v_cnt == YW'(V_ACTIVE));

  row_addr_reg #(.AW(AW), .BASE_ADDR(BASE_ADDR), .LINE_PITCH(LINE_PITCH)) u_addr (
    .clk_i, .rst_ni, .reload_i(reload), .adv_i(fill_req_o), .addr_o(row_addr_o)
  );

  assign hsync_no = !in_span(int'(h_cnt), H_ACTIVE + H_FP, H_SYNC);
  assign vsync_no = !in_span(int'(v_cnt), V_ACTIVE + V_FP, V_SYNC);
  assign de_o     = (int'(h_cnt) < H_ACTIVE) && (int'(v_cnt) < V_ACTIVE);
  assign x_o      = h_cnt;
  assign y_o      = v_cnt;

  p_fill_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |=> !fill_req_o);
  p_fill_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && y_o == YW'(V_TOTAL - 1)) |-> (row_addr_o == AW'(BASE_ADDR)));
  p_de_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_o) |-> (x_o == '0));
  p_vsync_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o != '0) |-> $stable(vsync_no));
  p_hsync_off_de_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> hsync_no);
endmodule

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;
  localparam real CLK_PERIOD = 20.834;
  localparam int HA = 16, HF = 2, HS = 4, HB = 3;
  localparam int VA = 6, VF = 2, VS = 1, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int PITCH = 16, BASE = 'h100, AW = 20;
  localparam int XW = $clog2(HT), YW = $clog2(VT);
  localparam int NCYC = 3 * HT * VT + 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hsync_no, vsync_no, de_o, fill_req_o;
  logic [AW-1:0] row_addr_o;
  logic [XW-1:0] x_o;
  logic [YW-1:0] y_o;

  lcd_timing_gen #(.H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                   .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
                   .LINE_PITCH(PITCH), .BASE_ADDR(BASE), .AW(AW)) u_dut (
    .clk_i, .rst_ni, .hsync_no, .vsync_no, .de_o, .fill_req_o,
    .row_addr_o, .x_o, .y_o
  );

  always #(CLK_PERIOD / 2.0) clk_i = ~clk_i;

  typedef struct {
    int k, x, y, addr;
    bit hs, vs, de, fill;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: expected stream from cycle number, per R2..R9
  task automatic push_expected(input int n);
    for (int k = 1; k <= n; k++) begin
      exp_t e;
      int idx = k - 1;
      e.k = k;
      e.x = idx % HT;
      e.y = (VT - 1 + idx / HT) % VT;
      e.hs = !(e.x >= HA + HF && e.x < HA + HF + HS);
      e.vs = !(e.y >= VA + VF && e.y < VA + VF + VS);
      e.de = (e.x < HA) && (e.y < VA);
      e.fill = (e.x == 0) && (e.y == VT - 1 || e.y < VA - 1);
      e.addr = BASE + ((e.y + 1) % VT) * PITCH;
      q.push_back(e);
    end
  endtask

  initial begin
    push_expected(NCYC);
    repeat (3) @(negedge clk_i);
    // R1 reset values
    check(hsync_no == 1'b1, "R1", "hsync_no", int'(hsync_no), 1);
    check(vsync_no == 1'b1, "R1", "vsync_no", int'(vsync_no), 1);
    check(de_o == 1'b0, "R1", "de_o", int'(de_o), 0);
    check(fill_req_o == 1'b0, "R1", "fill_req_o", int'(fill_req_o), 0);
    check(int'(row_addr_o) == BASE, "R1", "row_addr_o", int'(row_addr_o), BASE);
    rst_ni = 1'b1;
    // monitor: one item per rising edge since release
    while (q.size() > 0) begin
      exp_t e;
      @(negedge clk_i);
      e = q.pop_front();
      if (e.k == 1) begin
        check(int'(x_o) == 0 && int'(y_o) == VT - 1, "R9", "start position y",
              int'(y_o), VT - 1);
        check(fill_req_o == 1'b1, "R9", "first fill", int'(fill_req_o), 1);
      end
      check(int'(x_o) == e.x, "R2", "x_o", int'(x_o), e.x);
      check(int'(y_o) == e.y, "R4", "y_o", int'(y_o), e.y);
      check(hsync_no == e.hs, "R3", "hsync_no", int'(hsync_no), int'(e.hs));
      check(vsync_no == e.vs, "R4", "vsync_no", int'(vsync_no), int'(e.vs));
      check(de_o == e.de, "R5", "de_o", int'(de_o), int'(e.de));
      check(fill_req_o == e.fill, "R6", "fill_req_o", int'(fill_req_o), int'(e.fill));
      if (e.fill) begin
        if (e.y == VT - 1)
          check(int'(row_addr_o) == e.addr, "R8", "frame base addr",
                int'(row_addr_o), e.addr);
        else
          check(int'(row_addr_o) == e.addr, "R7", "row addr",
                int'(row_addr_o), e.addr);
      end
    end
    report();
  end

  initial begin
    #(CLK_PERIOD * (NCYC + 100));
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule